// File: doc/BRIEF.md
# Link Power State Controller

This block follows the power state that software assigns to a device and derives from it the power state of the serial link that attaches the device to its upstream port. While the device is fully on, the link sits in its active state. Two hardware idle timers may also move it into a light standby state or an autonomous deep-idle state. When software lowers the device state, the controller asks the upstream port for deep-idle entry. A turn-off message received in the deepest software state leads to a ready-for-power-removal state and is acknowledged with a single pulse.

Once main power is gone, the controller records whether auxiliary power is still present. With auxiliary power the result is the low-power state that can still wake the system; without it the result is the fully-off state. Restoring main power brings the controller back to the active link state with the device fully on. All outputs come from registers, and every decision takes effect at the clock edge on which its inputs are sampled.

Link state codes: 0 active, 1 standby, 2 deep idle, 3 ready for power removal, 4 auxiliary-powered off, 5 fully off. Device state codes: 0 fully on, 1 and 2 intermediate, 3 deepest powered state.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, link_state is 0 (active), dev_state is 0 (fully on), and turnoff_ack, l1_entry_req and wake_notify are all 0.
- R2: With dev_state 0, link_state 0 and l0s_en high, link_state becomes 1 (standby) at the edge that samples the l0s_limit-th consecutive idle cycle. A cycle with link_idle low in standby gives link_state 0 after the next edge.
- R3: When l0s_en is low, standby is never entered, however long link_idle stays high. When l1_aspm_en is also low, the link stays at 0.
- R4: With dev_state 0 and l1_aspm_en high, link_state becomes 2 at the edge that samples the l1_limit-th consecutive idle cycle, counted across states 0 and 1. In that autonomous state, a cycle with link_idle low returns link_state to 0 after one edge.
- R5: A write of device state 1, 2 or 3 (dev_state_wr with dev_state_in) updates dev_state after one edge. link_state becomes 2 after the following edge. l1_entry_req is high for exactly one cycle on every entry into link state 2.
- R6: Writing device state 0 while link_state is 2 and was entered because of the device state makes dev_state 0 after one edge and link_state 0 after the next.
- R7: turnoff_req while dev_state is 3 and link_state is 2 gives link_state 3 after one edge, together with a one-cycle turnoff_ack. In any other device state, turnoff_req changes nothing and gives no acknowledge.
- R8: In link state 3, main_pwr_ok low gives link_state 4 after one edge if aux_pwr_ok is high, and 5 if aux_pwr_ok is low.
- R9: wake_req in link state 4 raises wake_notify for the cycle after each sampled request. In link state 5, wake_req has no effect.
- R10: main_pwr_ok high in link state 4 or 5 gives link_state 0 and dev_state 0 after one edge.
- R11: Device state writes are ignored while link_state is 3, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_state_wr | input | 1 | Strobe: write dev_state_in as the new device state |
| dev_state_in | input | 2 | Device state value to write (0..3) |
| link_idle | input | 1 | High when the link carries no traffic this cycle |
| l0s_en | input | 1 | Enable for autonomous standby entry |
| l1_aspm_en | input | 1 | Enable for autonomous deep-idle entry |
| l0s_limit | input | CNT_W | Idle cycles needed before standby |
| l1_limit | input | CNT_W | Idle cycles needed before autonomous deep idle |
| turnoff_req | input | 1 | Strobe: turn-off request message received |
| main_pwr_ok | input | 1 | Main power present |
| aux_pwr_ok | input | 1 | Auxiliary power present |
| wake_req | input | 1 | Wake request from the device |
| link_state | output | 3 | Current link power state code |
| dev_state | output | 2 | Current device state code |
| turnoff_ack | output | 1 | One-cycle acknowledge of an accepted turn-off |
| l1_entry_req | output | 1 | One-cycle deep-idle entry request to the upstream port |
| wake_notify | output | 1 | Wake notification while auxiliary-powered |

## Verification
A wake request and the return of main power can both arrive while the link is in the auxiliary-powered off state. The bench drives both in the same cycle. After that single edge it expects wake_notify high, link_state 0 and dev_state 0 all at once, so neither event may hide the other. A second overlap is a device state write in the cycle an ASPM timer reaches its limit, and it is covered by the rule that timers run only while the registered device state is fully on.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
    localparam int LINK_W = 3;
    localparam int DEV_W  = 2;

    typedef enum logic [LINK_W-1:0] {
        LK_L0     = 3'd0,
        LK_STBY   = 3'd1,
        LK_DEEP   = 3'd2,
        LK_RDY    = 3'd3,
        LK_AUXOFF = 3'd4,
        LK_OFF    = 3'd5
    } link_e;

    typedef enum logic [DEV_W-1:0] {
        DS_ON   = 2'd0,
        DS_MID1 = 2'd1,
        DS_MID2 = 2'd2,
        DS_DEEP = 2'd3
    } dev_e;

    typedef struct packed {
        link_e link;
        logic  aspm_deep;
        logic  l1_req;
        logic  ack;
        logic  wake;
    } fsm_t;
endpackage

// File: rtl/lpm_idle_timer.sv
`timescale 1ns/1ps
module lpm_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             idle,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + 1'b1;
        hit      = en && idle && (cnt_next >= {1'b0, limit});
        if (en && idle) begin
            cnt_d = (&cnt_q) ? cnt_q : cnt_next[CNT_W-1:0];
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lpm_dev_state.sv
`timescale 1ns/1ps
module lpm_dev_state
    import lpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  dev_e wr_val,
    input  logic accept,
    input  logic force_on,
    output dev_e state
);
    dev_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (force_on)          state_d = DS_ON;
        else if (wr && accept) state_d = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DS_ON;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_state_wr,
    input  logic [1:0]       dev_state_in,
    input  logic             link_idle,
    input  logic             l0s_en,
    input  logic             l1_aspm_en,
    input  logic [CNT_W-1:0] l0s_limit,
    input  logic [CNT_W-1:0] l1_limit,
    input  logic             turnoff_req,
    input  logic             main_pwr_ok,
    input  logic             aux_pwr_ok,
    input  logic             wake_req,
    output logic [2:0]       link_state,
    output logic [1:0]       dev_state,
    output logic             turnoff_ack,
    output logic             l1_entry_req,
    output logic             wake_notify
);
    localparam int N_TMR = 2;

    fsm_t fsm_d, fsm_q;
    dev_e dev_q;
    logic wr_ok, force_on, tmr_en;
    logic [CNT_W-1:0] tmr_lim [N_TMR];
    logic [N_TMR-1:0] tmr_hit;

    assign tmr_lim[0] = l0s_limit;
    assign tmr_lim[1] = l1_limit;
    assign tmr_en = (dev_q == DS_ON) && (fsm_q.link == LK_L0 || fsm_q.link == LK_STBY);

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        lpm_idle_timer #(.CNT_W(CNT_W)) tmr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (tmr_en),
            .idle  (link_idle),
            .limit (tmr_lim[g]),
            .hit   (tmr_hit[g])
        );
    end

    lpm_dev_state dev_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (dev_state_wr),
        .wr_val   (dev_e'(dev_state_in)),
        .accept   (wr_ok),
        .force_on (force_on),
        .state    (dev_q)
    );

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.wake = 1'b0;
        wr_ok      = 1'b0;
        force_on   = 1'b0;
        unique case (fsm_q.link)
            LK_L0, LK_STBY: begin
                wr_ok = 1'b1;
                if (dev_q != DS_ON) begin
                    fsm_d.link      = LK_DEEP;
                    fsm_d.aspm_deep = 1'b0;
                end else if (l1_aspm_en && tmr_hit[1]) begin
                    fsm_d.link      = LK_DEEP;
                    fsm_d.aspm_deep = 1'b1;
                end else if (fsm_q.link == LK_STBY && !link_idle) begin
                    fsm_d.link = LK_L0;
                end else if (fsm_q.link == LK_L0 && l0s_en && tmr_hit[0]) begin
                    fsm_d.link = LK_STBY;
                end
            end
            LK_DEEP: begin
                wr_ok = 1'b1;
                if (dev_q == DS_DEEP && turnoff_req) begin
                    fsm_d.link = LK_RDY;
                    wr_ok      = 1'b0;
                end else if (dev_q == DS_ON) begin
                    if (!fsm_q.aspm_deep || !link_idle) begin
                        fsm_d.link      = LK_L0;
                        fsm_d.aspm_deep = 1'b0;
                    end
                end else begin
                    fsm_d.aspm_deep = 1'b0;
                end
            end
            LK_RDY: begin
                if (!main_pwr_ok) fsm_d.link = aux_pwr_ok ? LK_AUXOFF : LK_OFF;
            end
            LK_AUXOFF: begin
                fsm_d.wake = wake_req;
                if (main_pwr_ok) begin
                    fsm_d.link = LK_L0;
                    force_on   = 1'b1;
                end
            end
            LK_OFF: begin
                if (main_pwr_ok) begin
                    fsm_d.link = LK_L0;
                    force_on   = 1'b1;
                end
            end
            default: begin
                fsm_d.link = LK_L0;
                force_on   = 1'b1;
            end
        endcase
        fsm_d.l1_req = (fsm_d.link == LK_DEEP) && (fsm_q.link != LK_DEEP);
        fsm_d.ack    = (fsm_d.link == LK_RDY) && (fsm_q.link == LK_DEEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{link: LK_L0, aspm_deep: 1'b0, l1_req: 1'b0, ack: 1'b0, wake: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign link_state   = fsm_q.link;
    assign dev_state    = dev_q;
    assign turnoff_ack  = fsm_q.ack;
    assign l1_entry_req = fsm_q.l1_req;
    assign wake_notify  = fsm_q.wake;
endmodule

// File: rtl/lpm_ctrl_chk.sv
`timescale 1ns/1ps
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_idle,
    input logic       main_pwr_ok,
    input logic       aux_pwr_ok,
    input logic [2:0] link_state,
    input logic [1:0] dev_state,
    input logic       turnoff_ack,
    input logic       l1_entry_req,
    input logic       wake_notify
);
    a_r2_stby_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 3'd1 && !link_idle) |=> link_state == 3'd0);

    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        l1_entry_req |=> !l1_entry_req);

    a_r5_req_on_deep: assert property (@(posedge clk) disable iff (!rst_n)
        l1_entry_req |-> link_state == 3'd2);

    a_r7_ack_from_deep: assert property (@(posedge clk) disable iff (!rst_n)
        turnoff_ack |-> (link_state == 3'd3 && $past(link_state) == 3'd2 && $past(dev_state) == 2'd3));

    a_r8_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 3'd3 && !main_pwr_ok) |=> link_state == (aux_pwr_ok ? 3'd4 : 3'd5));

    a_r9_wake_aux_only: assert property (@(posedge clk) disable iff (!rst_n)
        wake_notify |-> $past(link_state) == 3'd4);

    a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == 3'd4 || link_state == 3'd5) && main_pwr_ok) |=> (link_state == 3'd0 && dev_state == 2'd0));

    a_r11_dev_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 3'd3) |=> $stable(dev_state));
endmodule

bind lpm_ctrl lpm_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_idle    (link_idle),
    .main_pwr_ok  (main_pwr_ok),
    .aux_pwr_ok   (aux_pwr_ok),
    .link_state   (link_state),
    .dev_state    (dev_state),
    .turnoff_ack  (turnoff_ack),
    .l1_entry_req (l1_entry_req),
    .wake_notify  (wake_notify)
);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_state_wr = 1'b0;
    logic [1:0] dev_state_in = 2'd0;
    logic link_idle = 1'b0;
    logic l0s_en = 1'b0;
    logic l1_aspm_en = 1'b0;
    logic [CNT_W-1:0] l0s_limit = 16'd4;
    logic [CNT_W-1:0] l1_limit = 16'd10;
    logic turnoff_req = 1'b0;
    logic main_pwr_ok = 1'b1;
    logic aux_pwr_ok = 1'b1;
    logic wake_req = 1'b0;
    logic [2:0] link_state;
    logic [1:0] dev_state;
    logic turnoff_ack, l1_entry_req, wake_notify;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lpm_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_state_wr(dev_state_wr), .dev_state_in(dev_state_in),
        .link_idle(link_idle), .l0s_en(l0s_en), .l1_aspm_en(l1_aspm_en),
        .l0s_limit(l0s_limit), .l1_limit(l1_limit), .turnoff_req(turnoff_req),
        .main_pwr_ok(main_pwr_ok), .aux_pwr_ok(aux_pwr_ok), .wake_req(wake_req),
        .link_state(link_state), .dev_state(dev_state), .turnoff_ack(turnoff_ack),
        .l1_entry_req(l1_entry_req), .wake_notify(wake_notify)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_dev(input logic [1:0] v);
        dev_state_wr = 1'b1;
        dev_state_in = v;
        step(1);
        dev_state_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "link_state", link_state, 0);
        check("R1", "dev_state", dev_state, 0);
        check("R1", "pulses", {turnoff_ack, l1_entry_req, wake_notify}, 0);
    endtask

    task automatic t_no_aspm;
        l0s_en = 1'b0; l1_aspm_en = 1'b0; link_idle = 1'b1;
        step(20);
        check("R3", "link stays active", link_state, 0);
        link_idle = 1'b0;
        step(1);
    endtask

    task automatic t_standby;
        l0s_en = 1'b1; l1_aspm_en = 1'b0; link_idle = 1'b1;
        step(3);
        check("R2", "before limit", link_state, 0);
        step(1);
        check("R2", "standby entered", link_state, 1);
        link_idle = 1'b0;
        step(1);
        check("R2", "standby exit", link_state, 0);
        step(1);
    endtask

    task automatic t_aspm_deep;
        l0s_en = 1'b1; l1_aspm_en = 1'b1; link_idle = 1'b1;
        step(9);
        check("R4", "standby before deep", link_state, 1);
        step(1);
        check("R4", "deep entered", link_state, 2);
        check("R5", "entry req", l1_entry_req, 1);
        step(1);
        check("R5", "entry req ends", l1_entry_req, 0);
        check("R4", "deep held while idle", link_state, 2);
        link_idle = 1'b0;
        step(1);
        check("R4", "deep exit on traffic", link_state, 0);
        l0s_en = 1'b0; l1_aspm_en = 1'b0;
        step(1);
    endtask

    task automatic t_dev_deep_and_back;
        write_dev(2'd2);
        check("R5", "dev written", dev_state, 2);
        check("R5", "link not yet deep", link_state, 0);
        step(1);
        check("R5", "link deep", link_state, 2);
        check("R5", "entry req", l1_entry_req, 1);
        write_dev(2'd0);
        check("R6", "dev on", dev_state, 0);
        check("R5", "entry req single", l1_entry_req, 0);
        step(1);
        check("R6", "link active", link_state, 0);
    endtask

    task automatic t_turnoff_ignored;
        write_dev(2'd1);
        step(1);
        check("R5", "deep in state 1", link_state, 2);
        turnoff_req = 1'b1;
        step(1);
        turnoff_req = 1'b0;
        check("R7", "ignored link", link_state, 2);
        check("R7", "ignored ack", turnoff_ack, 0);
    endtask

    task automatic t_turnoff_to(input logic aux);
        write_dev(2'd3);
        step(1);
        check("R7", "deep in state 3", link_state, 2);
        turnoff_req = 1'b1;
        step(1);
        turnoff_req = 1'b0;
        check("R7", "ready state", link_state, 3);
        check("R7", "ack pulse", turnoff_ack, 1);
        write_dev(2'd0);
        check("R7", "ack ends", turnoff_ack, 0);
        check("R11", "write ignored", dev_state, 3);
        main_pwr_ok = 1'b0; aux_pwr_ok = aux;
        step(1);
        check("R8", "power removed", link_state, aux ? 4 : 5);
    endtask

    task automatic t_aux_off_wake_and_restore;
        t_turnoff_to(1'b1);
        write_dev(2'd1);
        check("R11", "write ignored in 4", dev_state, 3);
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        check("R9", "wake notify", wake_notify, 1);
        step(1);
        check("R9", "wake ends", wake_notify, 0);
        wake_req = 1'b1; main_pwr_ok = 1'b1;
        step(1);
        wake_req = 1'b0;
        check("R9", "wake with restore", wake_notify, 1);
        check("R10", "link active", link_state, 0);
        check("R10", "dev on", dev_state, 0);
        step(1);
    endtask

    task automatic t_full_off;
        t_turnoff_to(1'b0);
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        check("R9", "no wake in 5", wake_notify, 0);
        check("R9", "still off", link_state, 5);
        main_pwr_ok = 1'b1; aux_pwr_ok = 1'b1;
        step(1);
        check("R10", "link active from off", link_state, 0);
        check("R10", "dev on from off", dev_state, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_no_aspm();
        t_standby();
        t_aspm_deep();
        t_dev_deep_and_back();
        t_turnoff_ignored();
        write_dev(2'd0);
        step(1);
        t_aux_off_wake_and_restore();
        t_full_off();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule